// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is the digital half of a supply supervisor. It takes the already-digitized result of a supply-low comparator, a power-fail comparator, and a supply-below-battery flag. From these it drives the system reset pair, a low-line flag, a power-fail flag, and a gated chip-enable. A software watchdog is built in. The processor must keep toggling `wdi`. If the level stays put for longer than the selected timeout, the block issues a stretched reset pulse and drops the fault flag `wdo_n`.

All timing is counted in pulses of `tick_en`, so one external timebase sets both the reset stretch and the watchdog periods. `wd_en` comes from the tri-level detector that sits outside the block. When that detector sees a floating or mid-level watchdog pin, `wd_en` is low and the watchdog is switched off. The parameter `TIME_SHIFT` divides all tick lengths by a power of two, which gives short runs in simulation or in test.

Top module: `supervisor_ctrl`

## Requirements
- R1: `rst_out_n` is low in any cycle where `sup_low` is 1. After `sup_low` returns to 0, it stays low for exactly STRETCH `tick_en` pulses. The same stretch follows the release of `rst_n`.
- R2: `rst_out` is always the inverse of `rst_out_n`.
- R3: With `wd_en`=1, if `wdi` keeps one level for the whole timeout period after reset releases, then `rst_out_n` goes low for a stretch of STRETCH ticks. `wdo_n` goes low at the same clock edge.
- R4: Every change of `wdi`, rising or falling, restarts the timeout. A `wdi` that toggles at intervals shorter than the period never causes a reset.
- R5: `wd_fast_sel`=1 selects a timeout of FAST ticks. `wd_fast_sel`=0 selects SLOW ticks.
- R6: With `wd_en`=0, the watchdog never times out, and `wdo_n` is 1 from the next clock edge onward.
- R7: After a timeout, `wdo_n` stays 0 until one of two events. A change of `wdi` sets it to 1 within three clock edges. A `sup_low` of 1 sets it to 1 at the next edge.
- R8: `low_line_n` is `~sup_low` in the same cycle, with no stretch in either direction.
- R9: `ce_out_n` equals `ce_in_n` while `sup_low`=0, and it is 1 while `sup_low`=1.
- R10: `pfail_n` is 0 when `pf_low`=1 or `vcc_below_batt`=1, and 1 otherwise.
- R11: The watchdog counter is held at zero while reset is asserted. Counting starts at release, so the first timeout comes exactly one period after `rst_out_n` rises.
- R12: Stretch and timeout counters advance only on cycles with `tick_en`=1.
- R13: The effective lengths are STRETCH_TICKS, FAST_TICKS and SLOW_TICKS shifted right by `TIME_SHIFT`, with a floor of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase pulse, one clock wide |
| sup_low | input | 1 | Supply-low comparator result, 1 = low |
| pf_low | input | 1 | Power-fail comparator result, 1 = below threshold |
| vcc_below_batt | input | 1 | 1 when supply is below the battery |
| wdi | input | 1 | Watchdog kick level (asynchronous) |
| wd_en | input | 1 | Watchdog enabled (0 = pin floating or mid-level) |
| wd_fast_sel | input | 1 | 1 = fast timeout, 0 = slow timeout |
| ce_in_n | input | 1 | Chip-enable in, active low |
| rst_out_n | output | 1 | System reset, active low |
| rst_out | output | 1 | System reset, active high |
| wdo_n | output | 1 | Watchdog fault, active low |
| low_line_n | output | 1 | Low-line flag, active low |
| pfail_n | output | 1 | Power-fail flag, active low |
| ce_out_n | output | 1 | Gated chip-enable, active low |

## Verification
The watchdog is driven in five ways, and each one separates a different fault:
- A constant `wdi` under both period selects proves the exact fast and slow lengths.
- A `wdi` toggling at half the fast period proves that both edges restart the count.
- A constant `wdi` with the enable low proves the disable path.
- A `wdi` that stays stuck across two timeouts shows that the counter restarts only at reset release.

Supply-low pulses are applied with a timebase that ticks every cycle and with one that ticks every third cycle. These separate counting on ticks from counting on clocks. The comparator combinations check the gating outputs, which have no stretch.

// File: rtl/sup_pkg.sv
package sup_pkg;

    localparam int unsigned SYNC_DEPTH = 2;

    // Scale a tick count down by a power of two, never below 2.
    function automatic int unsigned scale_ticks(input int unsigned base, input int unsigned sh);
        int unsigned v;
        v = base >> sh;
        return (v < 2) ? 2 : v;
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/sup_rst_stretch.sv
module sup_rst_stretch #(
    parameter int unsigned STRETCH = 50,
    parameter int unsigned CNT_W   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic sup_low,
    input  logic wd_timeout,
    output logic rst_active
);
    typedef struct packed {
        logic             hold;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sup_low || wd_timeout) begin
            s_d.hold = 1'b1;
            s_d.cnt  = '0;
        end else if (s_q.hold && tick_en) begin
            if (s_q.cnt == CNT_W'(STRETCH - 1)) begin
                s_d.hold = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.hold <= 1'b1;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rst_active = sup_low | s_q.hold;

    AST_HOLD_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sup_low |=> s_q.hold); // R1
    AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hold |-> (s_q.cnt < CNT_W'(STRETCH))); // R1
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int unsigned FAST  = 100,
    parameter int unsigned SLOW  = 1600,
    parameter int unsigned CNT_W = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic wdi_async,
    input  logic wd_en,
    input  logic fast_sel,
    input  logic sup_low,
    input  logic rst_active,
    output logic wd_timeout,
    output logic wdo_n
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic             wdo_n;
    } st_t;

    st_t s_d, s_q;
    logic             wdi_s;
    logic             kick;
    logic             run;
    logic [CNT_W-1:0] lim;

    sup_sync #(.STAGES(sup_pkg::SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (wdi_async),
        .d_sync  (wdi_s)
    );

    always_comb begin
        s_d        = s_q;
        kick       = wdi_s ^ s_q.prev;
        lim        = fast_sel ? CNT_W'(FAST) : CNT_W'(SLOW);
        run        = wd_en & ~rst_active & ~kick;
        wd_timeout = run & tick_en & (s_q.cnt >= (lim - CNT_W'(1)));
        s_d.prev   = wdi_s;
        if (!run) begin
            s_d.cnt = '0;
        end else if (tick_en) begin
            s_d.cnt = wd_timeout ? '0 : s_q.cnt + CNT_W'(1);
        end
        if (!wd_en || sup_low || kick) begin
            s_d.wdo_n = 1'b1;
        end else if (wd_timeout) begin
            s_d.wdo_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prev  <= 1'b0;
            s_q.cnt   <= '0;
            s_q.wdo_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign wdo_n = s_q.wdo_n;

    AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> (s_q.cnt == '0)); // R11
    AST_TIMEOUT_DROPS_WDO: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> !wdo_n); // R3
endmodule

// File: rtl/supervisor_ctrl.sv
module supervisor_ctrl #(
    parameter int unsigned STRETCH_TICKS = 50,
    parameter int unsigned FAST_TICKS    = 100,
    parameter int unsigned SLOW_TICKS    = 1600,
    parameter int unsigned TIME_SHIFT    = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic sup_low,
    input  logic pf_low,
    input  logic vcc_below_batt,
    input  logic wdi,
    input  logic wd_en,
    input  logic wd_fast_sel,
    input  logic ce_in_n,
    output logic rst_out_n,
    output logic rst_out,
    output logic wdo_n,
    output logic low_line_n,
    output logic pfail_n,
    output logic ce_out_n
);
    localparam int unsigned STR_EFF  = sup_pkg::scale_ticks(STRETCH_TICKS, TIME_SHIFT);
    localparam int unsigned FAST_EFF = sup_pkg::scale_ticks(FAST_TICKS, TIME_SHIFT);
    localparam int unsigned SLOW_EFF = sup_pkg::scale_ticks(SLOW_TICKS, TIME_SHIFT);
    localparam int unsigned WD_MAX   = (FAST_EFF > SLOW_EFF) ? FAST_EFF : SLOW_EFF;
    localparam int unsigned STR_W    = $clog2(STR_EFF + 1);
    localparam int unsigned WD_W     = $clog2(WD_MAX + 1);

    logic rst_active;
    logic wd_timeout;

    sup_rst_stretch #(.STRETCH(STR_EFF), .CNT_W(STR_W)) u_stretch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .sup_low    (sup_low),
        .wd_timeout (wd_timeout),
        .rst_active (rst_active)
    );

    sup_wdog #(.FAST(FAST_EFF), .SLOW(SLOW_EFF), .CNT_W(WD_W)) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .wdi_async  (wdi),
        .wd_en      (wd_en),
        .fast_sel   (wd_fast_sel),
        .sup_low    (sup_low),
        .rst_active (rst_active),
        .wd_timeout (wd_timeout),
        .wdo_n      (wdo_n)
    );

    always_comb begin
        rst_out_n  = ~rst_active;
        rst_out    = rst_active;
        low_line_n = ~sup_low;
        pfail_n    = ~(pf_low | vcc_below_batt);
        ce_out_n   = sup_low ? 1'b1 : ce_in_n;
    end

    AST_WD_FAULT_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> !rst_out_n); // R3
    AST_LOWLINE_CLEARS_WDO: assert property (@(posedge clk) disable iff (!rst_n)
        sup_low |=> wdo_n); // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_en |=> (wdo_n && !wd_timeout)); // R6
endmodule

// File: tb/sim_supervisor_ctrl.sv
module sim_supervisor_ctrl;
    localparam int S = 8;
    localparam int F = 12;
    localparam int L = 30;

    logic clk = 1'b0;
    logic rst_n, tick_en, sup_low, pf_low, vcc_below_batt, wdi, wd_en, wd_fast_sel, ce_in_n;
    logic rst_out_n, rst_out, wdo_n, low_line_n, pfail_n, ce_out_n;
    int   errors = 0;
    int   checks = 0;
    int   tick_div = 1;
    int   phase = 0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        phase   = (phase + 1 >= tick_div) ? 0 : phase + 1;
        tick_en = (phase == 0);
    end

    supervisor_ctrl #(.STRETCH_TICKS(16), .FAST_TICKS(24), .SLOW_TICKS(60), .TIME_SHIFT(1)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sup_low(sup_low), .pf_low(pf_low),
        .vcc_below_batt(vcc_below_batt), .wdi(wdi), .wd_en(wd_en), .wd_fast_sel(wd_fast_sel),
        .ce_in_n(ce_in_n), .rst_out_n(rst_out_n), .rst_out(rst_out), .wdo_n(wdo_n),
        .low_line_n(low_line_n), .pfail_n(pfail_n), .ce_out_n(ce_out_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    // Count samples while rst_out_n keeps level lvl
    task automatic measure(input logic lvl, input int max, output int n);
        n = 0;
        while (rst_out_n === lvl && n < max) begin
            n++;
            step();
        end
    endtask

    task automatic wait_release();
        int n;
        measure(1'b0, 1000, n);
    endtask

    task automatic t_reset();
        int n;
        check(rst_out_n === 1'b0, "R1 reset held", rst_out_n, 0);
        check(rst_out === 1'b1, "R2 complement in reset", rst_out, 1);
        check(wdo_n === 1'b1, "R6 wdo idle", wdo_n, 1);
        rst_n = 1'b1;
        #1;
        measure(1'b0, 1000, n);
        check(n == S, "R1 R13 power-on stretch", n, S);
        check(rst_out === 1'b1 - rst_out_n, "R2 complement after release", rst_out, 0);
    endtask

    task automatic t_lowline();
        int n;
        ce_in_n = 1'b0;
        sup_low = 1'b1;
        #1;
        check(low_line_n === 1'b0, "R8 low_line immediate", low_line_n, 0);
        check(rst_out_n === 1'b0, "R1 reset immediate", rst_out_n, 0);
        check(rst_out === 1'b1, "R2 complement", rst_out, 1);
        check(ce_out_n === 1'b1, "R9 ce forced high", ce_out_n, 1);
        repeat (5) step();
        sup_low = 1'b0;
        #1;
        check(low_line_n === 1'b1, "R8 low_line no stretch", low_line_n, 1);
        check(ce_out_n === 1'b0, "R9 ce follows low", ce_out_n, 0);
        ce_in_n = 1'b1;
        #1;
        check(ce_out_n === 1'b1, "R9 ce follows high", ce_out_n, 1);
        measure(1'b0, 1000, n);
        check(n == S, "R1 stretch after low", n, S);
    endtask

    task automatic t_pfail();
        for (int i = 0; i < 4; i++) begin
            pf_low = i[0];
            vcc_below_batt = i[1];
            #1;
            check(pfail_n === ~(i[0] | i[1]), "R10 power fail", pfail_n, ~(i[0] | i[1]));
        end
        pf_low = 1'b0;
        vcc_below_batt = 1'b0;
    endtask

    task automatic t_wd_fixed(input logic fast, input int per);
        int n;
        wd_en = 1'b0;
        wait_release();
        step();
        wd_fast_sel = fast;
        wd_en = 1'b1;
        #1;
        measure(1'b1, 1000, n);
        check(n == per, fast ? "R3 R5 fast period" : "R5 slow period", n, per);
        check(wdo_n === 1'b0, "R3 wdo low with reset", wdo_n, 0);
        measure(1'b0, 1000, n);
        check(n == S, "R3 watchdog stretch", n, S);
        check(wdo_n === 1'b0, "R7 wdo stays low", wdo_n, 0);
        measure(1'b1, 1000, n);
        check(n == per, "R11 period restarts at release", n, per);
        wd_en = 1'b0;
        step();
        check(wdo_n === 1'b1, "R6 disable lifts wdo", wdo_n, 1);
    endtask

    task automatic t_kick();
        int lows = 0;
        wd_en = 1'b0;
        wait_release();
        wd_fast_sel = 1'b1;
        wd_en = 1'b1;
        for (int k = 0; k < 12; k++) begin
            for (int c = 0; c < F / 2; c++) begin
                step();
                if (rst_out_n !== 1'b1) lows++;
            end
            wdi = ~wdi;
        end
        check(lows == 0, "R4 both edges kick", lows, 0);
        wd_en = 1'b0;
    endtask

    task automatic t_wdo_clear();
        int n;
        wd_en = 1'b0;
        wait_release();
        wd_fast_sel = 1'b1;
        wd_en = 1'b1;
        measure(1'b1, 1000, n);
        check(wdo_n === 1'b0, "R3 timeout seen", wdo_n, 0);
        wdi = ~wdi;
        repeat (4) step();
        check(wdo_n === 1'b1, "R7 wdi edge clears wdo", wdo_n, 1);
        wait_release();
        measure(1'b1, 1000, n);
        check(wdo_n === 1'b0, "R7 second timeout", wdo_n, 0);
        sup_low = 1'b1;
        step();
        check(wdo_n === 1'b1, "R7 low line clears wdo", wdo_n, 1);
        sup_low = 1'b0;
        wd_en = 1'b0;
    endtask

    task automatic t_disable();
        int bad = 0;
        wd_en = 1'b0;
        wait_release();
        for (int c = 0; c < 3 * L; c++) begin
            step();
            if (rst_out_n !== 1'b1 || wdo_n !== 1'b1) bad++;
        end
        check(bad == 0, "R6 disabled watchdog quiet", bad, 0);
    endtask

    task automatic t_tick();
        int n;
        tick_div = 3;
        wait_release();
        sup_low = 1'b1;
        repeat (4) step();
        sup_low = 1'b0;
        #1;
        measure(1'b0, 1000, n);
        check(n >= 3 * S - 3 && n <= 3 * S + 1, "R12 stretch on ticks", n, 3 * S);
        tick_div = 1;
        repeat (3) step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tick_en = 1'b1; sup_low = 1'b0; pf_low = 1'b0; vcc_below_batt = 1'b0;
        wdi = 1'b0; wd_en = 1'b0; wd_fast_sel = 1'b1; ce_in_n = 1'b1;
        repeat (3) step();
        t_reset();
        t_lowline();
        t_pfail();
        t_wd_fixed(1'b1, F);
        t_wd_fixed(1'b0, L);
        t_kick();
        t_wdo_clear();
        t_disable();
        t_tick();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule